// File: doc/BRIEF.md
# Two-Wire EEPROM Random Byte Reader

This block is a serial master for a two-wire EEPROM that uses a 16-bit word address. It reads one byte from any address. A single-cycle request with an address starts a transfer. The block first sends a dummy-write header: the write device select and then both address bytes. It then issues a repeated start and the read device select, and clocks in one data byte. After that byte it leaves the data line released, so no acknowledge is given, and it closes the transfer with a stop condition.

If the device does not acknowledge a byte the master sent, the block sends no further bytes. It goes directly to a stop condition and reports an error. The data line is open-drain: the block drives an output enable and an output value and samples the wire back. A parameter sets the length of half a bit period in system clocks. Every level on the bus is held for at least that long.

Top module: `eeprom_byte_reader`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe_o` is 0, and `busy_o`, `done_o` and `err_o` are all 0.
- R2: A transfer opens with a start condition (wire falls while `scl_o` is high). A second start condition is issued only after the low address byte has been acknowledged.
- R3: While `scl_o` stays high, the wire changes only for start and stop conditions. Data and acknowledge bits change only while `scl_o` is low.
- R4: Bytes are sent most significant bit first, one bit per `scl_o` pulse, in this order: 0xA0, `addr_i[15:8]`, `addr_i[7:0]`, repeated start, 0xA1.
- R5: After each sent byte the master releases the wire (`sda_oe_o` = 0) for a ninth pulse. It samples the acknowledge on that pulse, with 0 meaning acknowledged.
- R6: An acknowledge sampled as 1 on any sent byte ends the transfer with a stop condition. No further byte is sent, `err_o` is 1 and `data_o` is 0x00.
- R7: The data byte is sampled while `scl_o` is high, most significant bit first. On success it is returned on `data_o` with `err_o` = 0.
- R8: After the eighth data bit, the master keeps the wire released for one more `scl_o` pulse, so it does not acknowledge.
- R9: Every transfer, including an aborted one, ends with exactly one stop condition (wire rises while `scl_o` is high) before `done_o`.
- R10: `done_o` pulses high for one cycle at the end of each transfer, and `busy_o` is 0 in that cycle. `err_o` and `data_o` hold their values until the next request is accepted.
- R11: Each level of `scl_o`, `sda_oe_o` and `sda_o` is held for at least `HALF_CYC` clock cycles.
- R12: `req_i` is ignored while `busy_o` is 1: the address in flight does not change and no extra transfer or `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read; sampled only when idle |
| addr_i | input | 16 | Word address to read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Last transfer aborted on a missing acknowledge |
| data_o | output | 8 | Byte read by the last transfer |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | Data line output enable |
| sda_o | output | 1 | Data line output value when enabled |
| sda_i | input | 1 | Sampled data line |

## Verification
A bus-level device model decodes start and stop conditions and shifts the bytes in. It acknowledges bytes and returns an address-dependent byte. Reads at the addresses 0x0000, 0xFFFF and two mixed patterns show that the high and low address bytes are not swapped and that the bit order is most significant first. A missing acknowledge is injected on each of the four sent bytes in turn. This separates an abort before the repeated start (one start condition, three bytes or fewer seen) from an abort on the read select (two start conditions). A request raised in the middle of a transfer with a different address checks that the address in flight stays fixed and that no second transfer follows.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] DEV_SEL_WR = 8'hA0;
  localparam logic [DATA_W-1:0] DEV_SEL_RD = 8'hA1;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} eerd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TXBIT, ST_ACK, ST_RSTART, ST_RXBIT, ST_NACK, ST_STOP
  } eerd_st_e;

  typedef struct packed {
    logic scl;
    logic oe;
    logic o;
  } eerd_pins_t;

  localparam eerd_pins_t PINS_IDLE = '{scl: 1'b1, oe: 1'b0, o: 1'b1};

  function automatic logic [1:0] last_phase(eerd_op_e op);
    case (op)
      OP_START: last_phase = 2'd3;
      OP_STOP:  last_phase = 2'd2;
      default:  last_phase = 2'd1;
    endcase
  endfunction

  // bus levels per half-bit phase of each primitive
  function automatic eerd_pins_t phase_pins(eerd_op_e op, logic [1:0] ph, logic b);
    eerd_pins_t p;
    p = PINS_IDLE;
    case (op)
      OP_START: begin
        p.oe  = 1'b1;
        p.scl = (ph == 2'd1) || (ph == 2'd2);
        p.o   = (ph < 2'd2);
      end
      OP_STOP: begin
        p.scl = (ph != 2'd0);
        p.oe  = (ph != 2'd2);   // last phase releases: pull-up makes the rise
        p.o   = (ph == 2'd2);
      end
      OP_TX: begin
        p.scl = (ph == 2'd1);
        p.oe  = 1'b1;
        p.o   = b;
      end
      default: begin
        p.scl = (ph == 2'd1);
        p.oe  = 1'b0;
        p.o   = 1'b1;
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/eerd_half_timer.sv
module eerd_half_timer #(
  parameter int HALF_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eerd_bit_phy.sv
module eerd_bit_phy
  import eerd_pkg::*;
#(
  parameter int HALF_CYC = 125
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     op_valid_i,
  input  eerd_op_e op_i,
  input  logic     tx_bit_i,
  input  logic     sda_i,
  output logic     op_done_o,
  output logic     rx_bit_o,
  output logic     scl_o,
  output logic     sda_oe_o,
  output logic     sda_o
);
  localparam int HW = $clog2(HALF_CYC + 1) + 1;

  logic       act_q, bit_q, done_q, rx_q, tick;
  logic [1:0] ph_q;
  eerd_op_e   op_q;
  eerd_pins_t pins_q;

  eerd_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (act_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      op_q   <= OP_START;
      bit_q  <= 1'b0;
      ph_q   <= 2'd0;
      pins_q <= PINS_IDLE;
      done_q <= 1'b0;
      rx_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!act_q && op_valid_i) begin
        act_q  <= 1'b1;
        op_q   <= op_i;
        bit_q  <= tx_bit_i;
        ph_q   <= 2'd0;
        pins_q <= phase_pins(op_i, 2'd0, tx_bit_i);
      end else if (tick) begin
        if (ph_q == last_phase(op_q)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= sda_i;       // last cycle of the high phase
        end else begin
          ph_q   <= ph_q + 2'd1;
          pins_q <= phase_pins(op_q, ph_q + 2'd1, bit_q);
        end
      end
    end
  end

  assign op_done_o = done_q;
  assign rx_bit_o  = rx_q;
  assign scl_o     = pins_q.scl;
  assign sda_oe_o  = pins_q.oe;
  assign sda_o     = pins_q.o;

  // hold-time checker
  eerd_pins_t  prev_q;
  logic [HW-1:0] since_q;
  logic        chg;
  assign chg = (pins_q != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= PINS_IDLE;
      since_q <= HW'(HALF_CYC);
    end else begin
      prev_q  <= pins_q;
      if (chg)                        since_q <= HW'(1);
      else if (since_q < HW'(HALF_CYC)) since_q <= since_q + 1'b1;
    end
  end

  a_r11_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |-> (since_q >= HW'(HALF_CYC)));

  a_r3_data_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pins_q.scl) && pins_q.scl && (op_q == OP_TX || op_q == OP_RX))
      |-> $stable({pins_q.oe, pins_q.o}));

  a_r5_rx_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && op_q == OP_RX) |-> !pins_q.oe);

  a_r2_start_fall_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && op_q == OP_START && $fell(pins_q.o)) |-> (pins_q.scl && $past(pins_q.scl)));
endmodule

// File: rtl/eeprom_byte_reader.sv
module eeprom_byte_reader
  import eerd_pkg::*;
#(
  parameter int HALF_CYC = 125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] data_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  output logic              sda_o,
  input  logic              sda_i
);
  localparam int BCW = $clog2(DATA_W);

  eerd_st_e          state_q;
  logic              pend_q, err_q, done_q, err_out_q;
  logic [BCW-1:0]    bit_q;
  logic [1:0]        byte_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic [ADDR_W-1:0] addr_q;

  eerd_op_e op;
  logic     op_valid, ph_done, ph_rx;

  always_comb begin
    case (state_q)
      ST_START, ST_RSTART:       op = OP_START;
      ST_TXBIT:                  op = OP_TX;
      ST_STOP:                   op = OP_STOP;
      default:                   op = OP_RX;
    endcase
  end

  assign op_valid = (state_q != ST_IDLE) && !pend_q;

  eerd_bit_phy #(.HALF_CYC(HALF_CYC)) u_phy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid),
    .op_i       (op),
    .tx_bit_i   (sh_q[DATA_W-1]),
    .sda_i      (sda_i),
    .op_done_o  (ph_done),
    .rx_bit_o   (ph_rx),
    .scl_o      (scl_o),
    .sda_oe_o   (sda_oe_o),
    .sda_o      (sda_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      err_out_q <= 1'b0;
      bit_q     <= '0;
      byte_q    <= 2'd0;
      sh_q      <= '0;
      data_q    <= '0;
      addr_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_i) begin
          addr_q  <= addr_i;
          err_q   <= 1'b0;
          pend_q  <= 1'b0;
          state_q <= ST_START;
        end
      end else if (op_valid) begin
        pend_q <= 1'b1;
      end else if (ph_done) begin
        pend_q <= 1'b0;
        case (state_q)
          ST_START: begin
            sh_q    <= DEV_SEL_WR;
            byte_q  <= 2'd0;
            bit_q   <= BCW'(DATA_W - 1);
            state_q <= ST_TXBIT;
          end
          ST_TXBIT: begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            if (bit_q == '0) state_q <= ST_ACK;
            else             bit_q   <= bit_q - 1'b1;
          end
          ST_ACK: begin
            bit_q <= BCW'(DATA_W - 1);
            if (ph_rx) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP;
            end else begin
              case (byte_q)
                2'd0: begin sh_q <= addr_q[ADDR_W-1 -: DATA_W]; byte_q <= 2'd1; state_q <= ST_TXBIT; end
                2'd1: begin sh_q <= addr_q[DATA_W-1:0];         byte_q <= 2'd2; state_q <= ST_TXBIT; end
                2'd2: state_q <= ST_RSTART;
                default: state_q <= ST_RXBIT;
              endcase
            end
          end
          ST_RSTART: begin
            sh_q    <= DEV_SEL_RD;
            byte_q  <= 2'd3;
            bit_q   <= BCW'(DATA_W - 1);
            state_q <= ST_TXBIT;
          end
          ST_RXBIT: begin
            sh_q <= {sh_q[DATA_W-2:0], ph_rx};
            if (bit_q == '0) state_q <= ST_NACK;
            else             bit_q   <= bit_q - 1'b1;
          end
          ST_NACK: state_q <= ST_STOP;
          ST_STOP: begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            err_out_q <= err_q;
            data_q    <= err_q ? '0 : sh_q;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_out_q;
  assign data_o = data_q;

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r12_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_q));

  a_r6_abort_to_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && busy_o) |-> (state_q == ST_STOP));

  a_r9_stop_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(state_q) == ST_STOP));
endmodule

// File: tb/sim_eeprom_byte_reader.sv
module sim_eeprom_byte_reader;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic busy_o, done_o, err_o, scl_o, sda_oe_o, sda_o, sda_line;
  logic [7:0] data_o;
  logic slave_low = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = (sda_oe_o ? sda_o : 1'b1) & ~slave_low;

  eeprom_byte_reader #(.HALF_CYC(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .data_o(data_o),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_o(sda_o), .sda_i(sda_line)
  );

  int n_chk = 0, n_err = 0, done_cnt = 0;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic logic [7:0] mem_of(logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
  endfunction

  // device model
  logic [7:0] log_b [8];
  int nbytes, n_start, n_stop, n_hichg, nak_at, bitcnt, mode;
  logic got_mack, mack, last_ack, ps = 1'b1, pd = 1'b1;
  logic [7:0] sr, rdb;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (ps && scl_o && (pd != sda_line)) n_hichg++;
      if (ps && scl_o && pd && !sda_line) begin
        n_start++; bitcnt = 0; mode = 0; slave_low = 1'b0;
      end else if (ps && scl_o && !pd && sda_line) begin
        n_stop++; bitcnt = 0; mode = 0; slave_low = 1'b0;
      end else if (!ps && scl_o) begin
        if (mode == 0) begin
          if (bitcnt < 8) begin sr = {sr[6:0], sda_line}; bitcnt++; end
          else if (bitcnt == 8) bitcnt = 9;
        end else begin
          if (bitcnt < 8) bitcnt++;
          else if (bitcnt == 8) begin mack = sda_line; got_mack = 1'b1; bitcnt = 9; end
        end
      end else if (ps && !scl_o) begin
        if (mode == 0) begin
          if (bitcnt == 8) begin
            if (nbytes < 8) log_b[nbytes] = sr;
            last_ack = (nbytes != nak_at);
            slave_low = last_ack;
            nbytes++;
          end else if (bitcnt == 9) begin
            slave_low = 1'b0; bitcnt = 0;
            if (last_ack && sr == 8'hA1) begin
              mode = 1;
              rdb = mem_of({log_b[1], log_b[2]});
              slave_low = ~rdb[7];
            end
          end
        end else begin
          if (bitcnt >= 1 && bitcnt <= 7) slave_low = ~rdb[7-bitcnt];
          else if (bitcnt == 8) slave_low = 1'b0;
          else if (bitcnt == 9) begin mode = 0; bitcnt = 0; end
        end
      end
      ps = scl_o; pd = sda_line;
    end
  end

  // scoreboard monitor
  typedef struct { logic err; logic [7:0] data; } exp_t;
  exp_t exp_q[$];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_done && done_o) chk("R10 done longer than one cycle", 1, 0);
      if (done_o) begin
        done_cnt++;
        chk("R10 busy low with done", busy_o, 0);
        if (exp_q.size() == 0) chk("R12 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R6 err flag", err_o, e.err);
          chk("R7 read data", data_o, e.data);
        end
      end
      prev_done = done_o;
    end
  end

  // hold-time monitor
  int gap = 1000, min_gap = 1000;
  logic [2:0] prev_pins = 3'b101;
  always @(negedge clk) begin
    if (rst_ni) begin
      if ({scl_o, sda_oe_o, sda_o} != prev_pins) begin
        if (gap < min_gap) min_gap = gap;
        gap = 1;
      end else gap++;
      prev_pins = {scl_o, sda_oe_o, sda_o};
    end
  end

  task automatic clear_logs(int nak);
    @(posedge clk);
    nbytes = 0; n_start = 0; n_stop = 0; n_hichg = 0;
    got_mack = 1'b0; nak_at = nak;
  endtask

  task automatic wait_done(int d0);
    int lim = 0;
    while (done_cnt == d0 && lim < 20000) begin @(negedge clk); lim++; end
  endtask

  task automatic run_read(logic [15:0] a, int nak);
    exp_t e;
    int d0, exp_n, exp_s;
    logic [7:0] eb [4];
    clear_logs(nak);
    e.err  = (nak >= 0);
    e.data = e.err ? 8'h00 : mem_of(a);
    exp_q.push_back(e);
    d0 = done_cnt;
    @(negedge clk); req_i = 1'b1; addr_i = a;
    @(negedge clk); req_i = 1'b0;
    chk("R10 busy during transfer", busy_o, 1);
    wait_done(d0);
    repeat (4) @(negedge clk);
    eb[0] = 8'hA0; eb[1] = a[15:8]; eb[2] = a[7:0]; eb[3] = 8'hA1;
    exp_n = (nak < 0) ? 4 : nak + 1;
    exp_s = (nak < 0 || nak == 3) ? 2 : 1;
    chk("R4 R6 byte count", nbytes, exp_n);
    for (int i = 0; i < exp_n; i++) chk("R4 byte value", log_b[i], eb[i]);
    chk("R2 start count", n_start, exp_s);
    chk("R9 stop count", n_stop, 1);
    chk("R3 changes while clock high", n_hichg, exp_s + 1);
    if (nak < 0) begin
      chk("R8 no-ack pulse seen", got_mack, 1);
      chk("R8 master left line high", mack, 1);
      chk("R5 R7 ok result", err_o, 0);
    end
    chk("R10 idle after done", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    nak_at = -1; nbytes = 0; n_start = 0; n_stop = 0; n_hichg = 0;
    bitcnt = 0; mode = 0; got_mack = 0; mack = 0; last_ack = 0; sr = 0; rdb = 0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 scl idle", scl_o, 1);
    chk("R1 sda released", sda_oe_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0);

    run_read(16'h0000, -1);
    run_read(16'hFFFF, -1);
    run_read(16'h1234, -1);
    run_read(16'hA55A, -1);
    run_read(16'h00FF, 0);   // R6 device absent
    run_read(16'h1357, 1);   // R6 NAK on high address
    run_read(16'h2468, 2);   // R6 NAK on low address
    run_read(16'h8001, 3);   // R6 NAK on read select
    run_read(16'h4C3D, -1);  // recovery after aborts

    begin : r12_test
      exp_t e;
      int d0;
      clear_logs(-1);
      e.err = 1'b0; e.data = mem_of(16'h0F0F);
      exp_q.push_back(e);
      d0 = done_cnt;
      @(negedge clk); req_i = 1'b1; addr_i = 16'h0F0F;
      @(negedge clk); req_i = 1'b0;
      repeat (30) @(negedge clk);
      req_i = 1'b1; addr_i = 16'h7777;
      @(negedge clk); req_i = 1'b0;
      wait_done(d0);
      chk("R12 high address kept", log_b[1], 8'h0F);
      chk("R12 low address kept", log_b[2], 8'h0F);
      repeat (200) @(negedge clk);
      chk("R12 no second transfer", busy_o, 0);
      chk("R12 single done", done_cnt, d0 + 1);
    end

    chk("R11 minimum hold", (min_gap >= HALF), 1);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule